// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block tests a small synchronous single-port RAM without an external tester. After a start pulse it drives the RAM's address, write data and write enable through six pattern phases. In each phase it writes a background over the whole array and then reads the array back. Every read result is compared with the value the phase expects. The first mismatch is captured together with its address and phase number. When the last phase is complete the block raises a done flag, and it holds there until the next start pulse.

The RAM is expected to return read data one cycle after the address is presented with write enable low. The comparator carries each read's expected word, address and phase through that cycle of latency. This lets a failure be reported against the read that caused it, even when the sequencer has already moved on to the next phase.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is held, and until the first start, done_o, fail_o, ram_we_o, fail_addr_o and fail_phase_o are all 0.
- R2: Phases run in this order, with these index values: 0 solid zeros, 1 solid ones, 2 a single all-ones word walked over a zero background, 3 a single all-zeros word walked over a ones background, 4 galloping over zeros, 5 galloping over ones. With N = 2^AW words, done_o rises exactly 4N + 2(N + N(N+2)) + 2(N + N(2N+2)) clock edges after the edge that samples start_i, which is 512 for N = 8.
- R3: A data bit stuck at 1 is reported in phase 0. A data bit stuck at 0 is reported in phase 1. In both cases the reported address is the faulty word.
- R4: In the walking phases, writing the base word and then reading every word catches a write to one address that disturbs bit 0 of another address. The failure is reported at the victim address in phase 2.
- R5: In the galloping phases, every word is read alternately with the base word. This catches a word whose bit 0 reads wrong only when it is read directly after a read of one other address. The failure is reported at that word in phase 4.
- R6: Only the first mismatch is recorded. Later mismatches in the same run leave fail_addr_o and fail_phase_o unchanged, and fail_o stays high until the next accepted start.
- R7: Each comparison is made one cycle after the read is issued, and it is tagged with that read's own address and phase. A mismatch on the last read of phase 0 is reported as phase 0, even though the result arrives during phase 1.
- R8: On a fault-free RAM, fail_o is 0 when done_o rises.
- R9: done_o stays high, with ram_we_o low, until start_i is sampled. A start_i pulse during a run is ignored, and the run length is unchanged.
- R10: A start_i sampled while done clears fail_o and done_o on the same edge and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | DW | RAM read data, valid one cycle after a read |
| done_o | output | 1 | All phases complete |
| fail_o | output | 1 | A mismatch has been seen |
| fail_addr_o | output | AW | Address of the first mismatch |
| fail_phase_o | output | 3 | Phase index of the first mismatch |

## Verification
The pending comparison of the final read in a phase resolves in the same cycle as the first write of the next phase. The bench provokes this by making the top word's bit stuck at 1, so the last read of phase 0 fails. The result is judged by fail_phase_o reading 0 rather than 1. A second coincidence is a start pulse arriving in the middle of a run. This is judged by the total run length staying at the formula value.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int NUM_PHASES = 6;
  localparam int PHASE_W    = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FILL, ST_SCAN, ST_WBASE, ST_WALK,
    ST_GA, ST_GB, ST_RESTORE, ST_DONE
  } step_e;

  typedef enum logic [1:0] {K_SOLID, K_WALK, K_GALLOP} kind_e;

  function automatic kind_e phase_kind(logic [PHASE_W-1:0] p);
    case (p)
      3'd0, 3'd1: return K_SOLID;
      3'd2, 3'd3: return K_WALK;
      default:    return K_GALLOP;
    endcase
  endfunction
endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [AW-1:0]      addr_o,
  output logic [DW-1:0]      wdata_o,
  output logic               we_o,
  output logic               rd_o,
  output logic [DW-1:0]      exp_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               done_o,
  output logic               clr_o
);
  step_e              step_q;
  logic [PHASE_W-1:0] phase_q;
  logic [AW-1:0]      a_q, b_q;
  logic [DW-1:0]      bg, inv;
  logic               a_last, b_last, ph_last;
  kind_e              kind;

  // odd phases run over a ones background
  assign bg      = phase_q[0] ? {DW{1'b1}} : {DW{1'b0}};
  assign inv     = ~bg;
  assign a_last  = (a_q == {AW{1'b1}});
  assign b_last  = (b_q == {AW{1'b1}});
  assign ph_last = (phase_q == PHASE_W'(NUM_PHASES-1));
  assign kind    = phase_kind(phase_q);
  assign clr_o   = start_i && (step_q == ST_IDLE || step_q == ST_DONE);
  assign done_o  = (step_q == ST_DONE);
  assign phase_o = phase_q;

  always_comb begin
    addr_o  = a_q;
    wdata_o = bg;
    we_o    = 1'b0;
    rd_o    = 1'b0;
    exp_o   = bg;
    case (step_q)
      ST_FILL:    we_o = 1'b1;
      ST_SCAN:    rd_o = 1'b1;
      ST_WBASE:   begin we_o = 1'b1; addr_o = b_q; wdata_o = inv; end
      ST_WALK,
      ST_GA:      begin rd_o = 1'b1; exp_o = (a_q == b_q) ? inv : bg; end
      ST_GB:      begin rd_o = 1'b1; addr_o = b_q; exp_o = inv; end
      ST_RESTORE: begin we_o = 1'b1; addr_o = b_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      phase_q <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      case (step_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          step_q  <= ST_FILL;
          phase_q <= '0;
          a_q     <= '0;
          b_q     <= '0;
        end
        ST_FILL: begin
          a_q <= a_q + 1'b1;
          b_q <= '0;
          if (a_last) step_q <= (kind == K_SOLID) ? ST_SCAN : ST_WBASE;
        end
        ST_WBASE: begin
          a_q    <= '0;
          step_q <= (kind == K_WALK) ? ST_WALK : ST_GA;
        end
        ST_WALK: begin
          a_q <= a_q + 1'b1;
          if (a_last) step_q <= ST_RESTORE;
        end
        ST_GA: step_q <= ST_GB;
        ST_GB: begin
          a_q    <= a_q + 1'b1;
          step_q <= a_last ? ST_RESTORE : ST_GA;
        end
        ST_SCAN, ST_RESTORE: begin
          if (step_q == ST_SCAN) a_q <= a_q + 1'b1;
          else                   b_q <= b_q + 1'b1;
          if ((step_q == ST_SCAN && a_last) || (step_q == ST_RESTORE && b_last)) begin
            a_q <= '0;
            if (ph_last) step_q <= ST_DONE;
            else begin
              phase_q <= phase_q + 1'b1;
              step_q  <= ST_FILL;
            end
          end else if (step_q == ST_RESTORE) begin
            step_q <= ST_WBASE;
          end
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] exp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] phase_i,
  input  logic [DW-1:0] rdata_i,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [PW-1:0] fail_phase_o
);
  logic          pend_v;
  logic [DW-1:0] pend_exp;
  logic [AW-1:0] pend_addr;
  logic [PW-1:0] pend_phase;
  logic          mism;

  assign mism = pend_v && (rdata_i != pend_exp);

  // tag travels with the read through the RAM latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v     <= 1'b0;
      pend_exp   <= '0;
      pend_addr  <= '0;
      pend_phase <= '0;
    end else begin
      pend_v     <= rd_i && !clr_i;
      pend_exp   <= exp_i;
      pend_addr  <= addr_i;
      pend_phase <= phase_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_phase_o <= '0;
    end else if (clr_i) begin
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_phase_o <= '0;
    end else if (mism && !fail_o) begin
      fail_o       <= 1'b1;
      fail_addr_o  <= pend_addr;
      fail_phase_o <= pend_phase;
    end
  end
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [AW-1:0]      ram_addr_o,
  output logic [DW-1:0]      ram_wdata_o,
  output logic               ram_we_o,
  input  logic [DW-1:0]      ram_rdata_i,
  output logic               done_o,
  output logic               fail_o,
  output logic [AW-1:0]      fail_addr_o,
  output logic [PHASE_W-1:0] fail_phase_o
);
  logic               rd, clr;
  logic [DW-1:0]      exp_w;
  logic [PHASE_W-1:0] phase;

  mbist_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .addr_o  (ram_addr_o),
    .wdata_o (ram_wdata_o),
    .we_o    (ram_we_o),
    .rd_o    (rd),
    .exp_o   (exp_w),
    .phase_o (phase),
    .done_o  (done_o),
    .clr_o   (clr)
  );

  mbist_cmp #(.AW(AW), .DW(DW), .PW(PHASE_W)) u_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .rd_i         (rd),
    .exp_i        (exp_w),
    .addr_i       (ram_addr_o),
    .phase_i      (phase),
    .rdata_i      (ram_rdata_i),
    .fail_o       (fail_o),
    .fail_addr_o  (fail_addr_o),
    .fail_phase_o (fail_phase_o)
  );
endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
  parameter int AW = 3,
  parameter int PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ram_we_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [PW-1:0] fail_phase_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !done_o && !fail_o && !ram_we_o);

  assert_phase_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> fail_phase_o < PW'(6));

  assert_first_fail_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o && $stable(fail_addr_o) && $stable(fail_phase_o));

  assert_fail_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> !$past(ram_we_o, 2));

  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ram_we_o);

  assert_restart_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !fail_o && !done_o);
endmodule

bind mbist_ctrl mbist_ctrl_chk #(.AW(AW), .PW(mbist_pkg::PHASE_W)) u_chk (.*);

// File: tb/mbist_ctrl_test.sv
module mbist_ctrl_test;
  localparam int PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int RUN_LEN = 4*N + 2*(N + N*(N+2)) + 2*(N + N*(2*N+2));

  // fault modes: 0 none, 1 stuck-0, 2 stuck-1, 3 write coupling, 4 read-sequence
  typedef struct packed {
    logic [2:0] mode;
    logic [2:0] addr;
    logic [2:0] bitn;
    logic [2:0] aux;
    logic       ef;
    logic [2:0] ea;
    logic [2:0] ep;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 3'd0},  // R8 clean
    '{3'd2, 3'd2, 3'd5, 3'd0, 1'b1, 3'd2, 3'd0},  // R3 R6 stuck-1
    '{3'd1, 3'd5, 3'd0, 3'd0, 1'b1, 3'd5, 3'd1},  // R3 stuck-0
    '{3'd2, 3'd7, 3'd7, 3'd0, 1'b1, 3'd7, 3'd0},  // R7 last read of phase 0
    '{3'd3, 3'd1, 3'd0, 3'd6, 1'b1, 3'd1, 3'd2},  // R4 coupling 6 -> 1
    '{3'd4, 3'd2, 3'd0, 3'd5, 1'b1, 3'd2, 3'd4}   // R5 read 5 then 2
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr, fail_addr;
  logic [DW-1:0] wdata, rdata, rdata_q;
  logic we, done, fail;
  logic [2:0] fail_phase;
  int checks = 0, errors = 0;

  logic [2:0] f_mode = 0, f_addr = 0, f_bit = 0, f_aux = 0;
  logic [DW-1:0] mem [N];
  logic [AW-1:0] rd_addr_q = '0, prev_a = '0;
  logic prev_rd = 1'b0, flip_q = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mbist_ctrl #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ram_addr_o(addr), .ram_wdata_o(wdata), .ram_we_o(we), .ram_rdata_i(rdata),
    .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr), .fail_phase_o(fail_phase)
  );

  always @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      if (f_mode == 3 && addr == f_aux) mem[f_addr][0] <= wdata[0];
    end
    rdata_q   <= mem[addr];
    rd_addr_q <= addr;
    flip_q    <= (f_mode == 4) && !we && prev_rd && prev_a == f_aux && addr == f_addr;
    prev_rd   <= !we;
    prev_a    <= addr;
  end

  always_comb begin
    rdata = rdata_q;
    if (rd_addr_q == f_addr && f_mode == 1) rdata[f_bit] = 1'b0;
    if (rd_addr_q == f_addr && f_mode == 2) rdata[f_bit] = 1'b1;
    rdata[0] = rdata[0] ^ flip_q;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input bit poke_mid, output int len);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    len = 0;
    while (!done && len < 5000) begin
      @(negedge clk);
      len++;
      if (poke_mid && len == 100) start = 1'b1;
      if (poke_mid && len == 101) start = 1'b0;
    end
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 fail in reset", int'(fail), 0);
    check("R1 we in reset", int'(we), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done before start", int'(done), 0);
    check("R1 fail_addr before start", int'(fail_addr), 0);
    check("R1 fail_phase before start", int'(fail_phase), 0);

    for (int i = 0; i < 6; i++) begin
      f_mode = VECS[i].mode; f_addr = VECS[i].addr;
      f_bit  = VECS[i].bitn; f_aux  = VECS[i].aux;
      run(1'b0, len);
      check("R2 run length", len, RUN_LEN);
      check("R3 R4 R5 R8 fail flag", int'(fail), int'(VECS[i].ef));
      if (VECS[i].ef) begin
        check("R3 R4 R5 R6 R7 fail address", int'(fail_addr), int'(VECS[i].ea));
        check("R2 R6 R7 fail phase", int'(fail_phase), int'(VECS[i].ep));
      end
    end

    // R9: done holds, no writes
    repeat (20) @(negedge clk);
    check("R9 done held", int'(done), 1);
    check("R9 no write while done", int'(we), 0);

    // R10: fault from last vector left fail high; restart clears it
    check("R10 fail high before restart", int'(fail), 1);
    f_mode = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R10 fail cleared", int'(fail), 0);
    check("R10 done cleared", int'(done), 0);
    while (!done) @(negedge clk);

    // R9: start mid-run ignored
    run(1'b1, len);
    check("R9 run length with mid-run start", len, RUN_LEN);
    check("R9 R8 clean after mid-run start", int'(fail), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule